// File: doc/BRIEF.md
# Frame-Scheduled FIFO Data Flow Router

This block visits a set of channel FIFOs once in every 125 µs frame, one step per clock, and steers bytes for each visit between the channel FIFO, an E1 line time-slot buffer and a PCM bus time-slot buffer. Each channel owns two steps, a transmit step and a receive step. By default the steps run in ascending order, with the two steps of each channel next to each other. The walk ends at a configurable last channel. A list mode replaces this ascending order with a list of (channel, direction) entries of configurable length.

For each step the block reads the visited channel's settings from an external configuration RAM through an asynchronous read port: a 3-bit flow mode, an E1 slot number and a PCM slot number. It also reads the two receive slot buffers through asynchronous ports, and it issues at most one write strobe per slot buffer in the step's cycle. The FIFO side uses valid/ready, with these back-pressure rules. The block never waits. In a transmit step it raises `fifo_tx_ready` for one cycle only when the flow mode needs the FIFO byte, and a byte moves only if `fifo_tx_valid` is high in that cycle. In a receive step it raises `fifo_rx_valid` for one cycle, and the byte is taken only if `fifo_rx_ready` is high. A missed handshake skips the byte and sets the channel's error flag. The error flags report the current frame and are cleared by the next frame start.

Top module: `fifo_flow_router`

## Requirements
- R1: After reset, `step_valid`, `fifo_tx_ready`, `fifo_rx_valid`, `e1_wr_en` and `pcm_wr_en` are low and `err_flags` is all zero, and they stay so until `frame_start`.
- R2: With `seq_mode`=0, the cycle after a `frame_start` cycle runs step 0. Step k visits channel k/2, with direction k mod 2 (0 = transmit, 1 = receive). There is one step per cycle through the receive step of `last_chan`, and after that `step_valid` stays low.
- R3: With `seq_mode`=1, the block puts index k on `seq_idx` for step k = 0 .. `seq_len`-1 and visits `seq_chan`/`seq_dir` in that order. With `seq_len`=0, a frame runs no step.
- R4: In a transmit step whose mode bit 1 is 0 and whose FIFO byte is available, the FIFO byte is written to E1 slot `cfg_e1_slot`. A transmit step with mode bit 1 set writes no E1 slot.
- R5: In a transmit step, the PCM slot `cfg_pcm_slot` is written as set by mode bit 2. With bit 2 = 1 it always gets the byte read from the E1 receive slot that has the same number as `cfg_e1_slot`. With bit 2 = 0 it gets the FIFO byte, and only when that byte is available.
- R6: Mode bit 0 has no effect on any output during a transmit step.
- R7: In a receive step, the FIFO write byte comes from the E1 receive slot when mode bit 0 is 0, and from the PCM receive slot when it is 1. The block asserts `fifo_rx_valid` for exactly that cycle.
- R8: In a receive step with mode bit 1 = 1, the PCM receive slot byte is written to E1 slot `cfg_e1_slot`. With bit 1 = 0 no E1 write occurs. A receive step never writes a PCM slot.
- R9: `fifo_tx_ready` is high only in a transmit step whose mode has bit 1 = 0 or bit 2 = 0. It is never high in a receive step or while idle.
- R10: A transmit step that needs the FIFO byte but sees `fifo_tx_valid` low sets `err_flags[channel]`. So does a receive step that sees `fifo_rx_ready` low. Flags hold through the frame and clear on the next `frame_start`.
- R11: Writes to one slot buffer are issued in step order, so when two steps of a frame target the same slot, the later step's byte stays.
- R12: A `frame_start` during a running walk restarts it at step 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| seq_mode | input | 1 | 0 = ascending walk, 1 = list walk |
| last_chan | input | CH_W | Last channel visited in ascending walk |
| seq_len | input | STEP_W+1 | Number of list entries in list walk |
| seq_idx | output | STEP_W | List entry index being read |
| seq_chan | input | CH_W | Channel of list entry at `seq_idx` |
| seq_dir | input | 1 | Direction of list entry (0 transmit, 1 receive) |
| step_valid | output | 1 | A step executes in this cycle |
| cur_chan | output | CH_W | Channel of current step; also config RAM and FIFO select |
| cur_dir | output | 1 | Direction of current step |
| cfg_mode | input | 3 | Flow mode of `cur_chan` |
| cfg_e1_slot | input | SLOT_W | E1 slot number of `cur_chan` |
| cfg_pcm_slot | input | SLOT_W | PCM slot number of `cur_chan` |
| fifo_tx_valid | input | 1 | Transmit FIFO of `cur_chan` has a byte |
| fifo_tx_data | input | DW | Transmit FIFO head byte |
| fifo_tx_ready | output | 1 | Pop transmit FIFO (handshake with valid) |
| fifo_rx_valid | output | 1 | Byte offered to receive FIFO |
| fifo_rx_data | output | DW | Receive FIFO byte |
| fifo_rx_ready | input | 1 | Receive FIFO of `cur_chan` has room |
| e1_rd_slot | output | SLOT_W | E1 receive buffer read slot |
| e1_rd_data | input | DW | E1 receive buffer byte |
| e1_wr_en | output | 1 | E1 transmit buffer write strobe |
| e1_wr_slot | output | SLOT_W | E1 transmit buffer write slot |
| e1_wr_data | output | DW | E1 transmit buffer write byte |
| pcm_rd_slot | output | SLOT_W | PCM receive buffer read slot |
| pcm_rd_data | input | DW | PCM receive buffer byte |
| pcm_wr_en | output | 1 | PCM transmit buffer write strobe |
| pcm_wr_slot | output | SLOT_W | PCM transmit buffer write slot |
| pcm_wr_data | output | DW | PCM transmit buffer write byte |
| err_flags | output | NCH | Per-channel skip flags for the current frame |

## Verification
A first frame gives every channel a different flow mode, so all eight modes are tried in both directions with every FIFO ready. This separates the switch positions and shows that bit 0 changes nothing in transmit steps. Further frames starve alternating transmit FIFOs and fill alternating receive FIFOs under a permuted mode map, which tells FIFO-sourced writes from E1-sourced ones and checks which channels get error flags. Short ascending walks, reversed and partial lists, and an empty list show where the walk ends. Two channels that share one E1 slot, run first in ascending order and then in reversed list order, show that the later step's byte stays. A restarted frame checks that the walk begins again at step 0.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

  // flow mode bit positions
  localparam int MB_RXSRC = 0;  // receive: 0 = E1, 1 = PCM
  localparam int MB_E1SEL = 1;  // transmit: block FIFO->E1; receive: PCM->E1
  localparam int MB_PCMSRC = 2;  // transmit: 0 = FIFO, 1 = E1 receive slot
endpackage

// File: rtl/fr_step_seq.sv
module fr_step_seq #(
  parameter int NCH = 32,
  localparam int CH_W = $clog2(NCH),
  localparam int STEP_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              seq_mode,
  input  logic [CH_W-1:0]   last_chan,
  input  logic [STEP_W:0]   seq_len,
  input  logic [CH_W-1:0]   seq_chan,
  input  logic              seq_dir,
  output logic [STEP_W-1:0] step_idx,
  output logic              busy,
  output logic [CH_W-1:0]   chan,
  output fr_pkg::dir_e      dir
);
  logic [STEP_W-1:0] step_q;
  logic              busy_q;
  logic [STEP_W:0]   last_idx;
  logic              at_last;
  logic              start_ok;

  always_comb begin
    if (seq_mode) last_idx = seq_len - 1'b1;
    else          last_idx = {1'b0, last_chan, 1'b1};
  end

  assign at_last  = ({1'b0, step_q} == last_idx);
  assign start_ok = seq_mode ? (seq_len != '0) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (frame_start) begin
      busy_q <= start_ok;
      step_q <= '0;
    end else if (busy_q) begin
      if (at_last) busy_q <= 1'b0;
      else         step_q <= step_q + 1'b1;
    end
  end

  assign step_idx = step_q;
  assign busy     = busy_q;
  assign chan     = seq_mode ? seq_chan : step_q[STEP_W-1:1];
  assign dir      = fr_pkg::dir_e'(seq_mode ? seq_dir : step_q[0]);

  // R12
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && start_ok) |=> (busy && step_idx == '0));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_start && !at_last) |=> (busy && step_idx == $past(step_idx) + 1'b1));

  // R2
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_start && at_last) |=> !busy);
endmodule

// File: rtl/fr_switch.sv
module fr_switch #(
  parameter int DW = 8
) (
  input  logic          active,
  input  fr_pkg::dir_e  dir,
  input  logic [2:0]    mode,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          rx_ready,
  input  logic [DW-1:0] e1_in,
  input  logic [DW-1:0] pcm_in,
  output logic          e1_we,
  output logic [DW-1:0] e1_out,
  output logic          pcm_we,
  output logic [DW-1:0] pcm_out,
  output logic          skip
);
  import fr_pkg::*;

  logic is_tx, is_rx, need_fifo, have_byte;

  assign is_tx     = active && (dir == DIR_TX);
  assign is_rx     = active && (dir == DIR_RX);
  assign need_fifo = !mode[MB_E1SEL] || !mode[MB_PCMSRC];
  assign have_byte = tx_valid;

  always_comb begin
    tx_ready = 1'b0;
    rx_valid = 1'b0;
    rx_data  = '0;
    e1_we    = 1'b0;
    e1_out   = '0;
    pcm_we   = 1'b0;
    pcm_out  = '0;
    skip     = 1'b0;
    if (is_tx) begin
      tx_ready = need_fifo;
      skip     = need_fifo && !have_byte;
      if (!mode[MB_E1SEL] && have_byte) begin
        e1_we  = 1'b1;
        e1_out = tx_data;
      end
      if (mode[MB_PCMSRC]) begin
        pcm_we  = 1'b1;
        pcm_out = e1_in;
      end else if (have_byte) begin
        pcm_we  = 1'b1;
        pcm_out = tx_data;
      end
    end else if (is_rx) begin
      rx_valid = 1'b1;
      rx_data  = mode[MB_RXSRC] ? pcm_in : e1_in;
      skip     = !rx_ready;
      if (mode[MB_E1SEL]) begin
        e1_we  = 1'b1;
        e1_out = pcm_in;
      end
    end
  end
endmodule

// File: rtl/fr_err_flags.sv
module fr_err_flags #(
  parameter int NCH = 32,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            skip,
  input  logic [CH_W-1:0] chan,
  output logic [NCH-1:0]  flags
);
  for (genvar i = 0; i < NCH; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)           flag_q <= 1'b0;
      else if (frame_start) flag_q <= 1'b0;
      else if (skip && chan == CH_W'(i)) flag_q <= 1'b1;
    end
    assign flags[i] = flag_q;
  end

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (flags == '0));
endmodule

// File: rtl/fifo_flow_router.sv
module fifo_flow_router #(
  parameter int NCH = 32,
  parameter int DW = 8,
  parameter int SLOT_W = 5,
  localparam int CH_W = $clog2(NCH),
  localparam int STEP_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              seq_mode,
  input  logic [CH_W-1:0]   last_chan,
  input  logic [STEP_W:0]   seq_len,
  output logic [STEP_W-1:0] seq_idx,
  input  logic [CH_W-1:0]   seq_chan,
  input  logic              seq_dir,
  output logic              step_valid,
  output logic [CH_W-1:0]   cur_chan,
  output logic              cur_dir,
  input  logic [2:0]        cfg_mode,
  input  logic [SLOT_W-1:0] cfg_e1_slot,
  input  logic [SLOT_W-1:0] cfg_pcm_slot,
  input  logic              fifo_tx_valid,
  input  logic [DW-1:0]     fifo_tx_data,
  output logic              fifo_tx_ready,
  output logic              fifo_rx_valid,
  output logic [DW-1:0]     fifo_rx_data,
  input  logic              fifo_rx_ready,
  output logic [SLOT_W-1:0] e1_rd_slot,
  input  logic [DW-1:0]     e1_rd_data,
  output logic              e1_wr_en,
  output logic [SLOT_W-1:0] e1_wr_slot,
  output logic [DW-1:0]     e1_wr_data,
  output logic [SLOT_W-1:0] pcm_rd_slot,
  input  logic [DW-1:0]     pcm_rd_data,
  output logic              pcm_wr_en,
  output logic [SLOT_W-1:0] pcm_wr_slot,
  output logic [DW-1:0]     pcm_wr_data,
  output logic [NCH-1:0]    err_flags
);
  fr_pkg::dir_e dir;
  logic         skip;

  fr_step_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .seq_mode(seq_mode), .last_chan(last_chan), .seq_len(seq_len),
    .seq_chan(seq_chan), .seq_dir(seq_dir),
    .step_idx(seq_idx), .busy(step_valid), .chan(cur_chan), .dir(dir)
  );

  assign cur_dir = dir;

  fr_switch #(.DW(DW)) u_sw (
    .active(step_valid), .dir(dir), .mode(cfg_mode),
    .tx_valid(fifo_tx_valid), .tx_data(fifo_tx_data), .tx_ready(fifo_tx_ready),
    .rx_valid(fifo_rx_valid), .rx_data(fifo_rx_data), .rx_ready(fifo_rx_ready),
    .e1_in(e1_rd_data), .pcm_in(pcm_rd_data),
    .e1_we(e1_wr_en), .e1_out(e1_wr_data),
    .pcm_we(pcm_wr_en), .pcm_out(pcm_wr_data),
    .skip(skip)
  );

  // receive slot shares its number with the transmit slot
  assign e1_rd_slot  = cfg_e1_slot;
  assign e1_wr_slot  = cfg_e1_slot;
  assign pcm_rd_slot = cfg_pcm_slot;
  assign pcm_wr_slot = cfg_pcm_slot;

  fr_err_flags #(.NCH(NCH)) u_err (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .skip(skip), .chan(cur_chan), .flags(err_flags)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |-> !(fifo_tx_ready || fifo_rx_valid || e1_wr_en || pcm_wr_en));

  // R9
  tx_pop_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_tx_ready |-> (step_valid && !cur_dir));

  // R8
  rx_no_pcm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && cur_dir) |-> (!pcm_wr_en && !fifo_tx_ready));

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_tx_ready && !fifo_tx_valid && !frame_start) |=> err_flags[$past(cur_chan)]);

  // R10
  rx_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rx_valid && !fifo_rx_ready && !frame_start) |=> err_flags[$past(cur_chan)]);
endmodule

// File: tb/sim_fifo_flow_router.sv
module sim_fifo_flow_router;
  localparam int NCH = 8;
  localparam int DW = 8;
  localparam int SW = 4;
  localparam int CW = 3;
  localparam int STW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic frame_start = 1'b0, seq_mode = 1'b0;
  logic [CW-1:0] last_chan = 3'd7;
  logic [STW:0] seq_len = '0;
  logic [STW-1:0] seq_idx;
  logic [CW-1:0] seq_chan, cur_chan;
  logic seq_dir, step_valid, cur_dir;
  logic [2:0] cfg_mode;
  logic [SW-1:0] cfg_e1_slot, cfg_pcm_slot, e1_rd_slot, e1_wr_slot, pcm_rd_slot, pcm_wr_slot;
  logic fifo_tx_valid, fifo_tx_ready, fifo_rx_valid, fifo_rx_ready, e1_wr_en, pcm_wr_en;
  logic [DW-1:0] fifo_tx_data, fifo_rx_data, e1_rd_data, e1_wr_data, pcm_rd_data, pcm_wr_data;
  logic [NCH-1:0] err_flags;

  // bench configuration and buffer models
  logic [2:0]    mode_a [NCH];
  logic [SW-1:0] e1s [NCH];
  logic [SW-1:0] pcms [NCH];
  logic          avail [NCH];
  logic          room [NCH];
  logic [DW-1:0] txd [NCH];
  logic [CW-1:0] lch [2*NCH];
  logic          ldir [2*NCH];
  logic [DW-1:0] e1tx [1<<SW];

  always_comb begin
    seq_chan      = lch[seq_idx];
    seq_dir       = ldir[seq_idx];
    cfg_mode      = mode_a[cur_chan];
    cfg_e1_slot   = e1s[cur_chan];
    cfg_pcm_slot  = pcms[cur_chan];
    fifo_tx_valid = avail[cur_chan];
    fifo_tx_data  = txd[cur_chan];
    fifo_rx_ready = room[cur_chan];
    e1_rd_data    = 8'hA0 + DW'(e1_rd_slot);
    pcm_rd_data   = 8'h50 + DW'(pcm_rd_slot);
  end

  always_ff @(posedge clk) if (e1_wr_en) e1tx[e1_wr_slot] <= e1_wr_data;

  fifo_flow_router #(.NCH(NCH), .DW(DW), .SLOT_W(SW)) u0 (.*);

  int checks = 0, errors = 0;
  logic [NCH-1:0] exp_err;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] e1v(input int s); return 8'hA0 + 8'(s); endfunction
  function automatic logic [7:0] pcmv(input int s); return 8'h50 + 8'(s); endfunction

  // checks the outputs of one step against arithmetic expectations
  task automatic check_step(input int ch, input bit dir, input string seqtag);
    logic [2:0] m;
    logic need;
    m = mode_a[ch];
    check({seqtag, " step"}, {29'd0, step_valid, cur_dir, 1'b0} | 32'(cur_chan) << 8,
          {29'd0, 1'b1, dir, 1'b0} | 32'(ch) << 8);
    if (!dir) begin
      need = !m[1] || !m[2];
      check("R9 tx pop", {31'd0, fifo_tx_ready}, {31'd0, need});
      check("R4 R6 tx e1", {15'd0, e1_wr_en, 8'd0, (e1_wr_en ? e1_wr_data : 8'd0)},
            {15'd0, (!m[1] && avail[ch]), 8'd0, ((!m[1] && avail[ch]) ? txd[ch] : 8'd0)});
      if (!m[1] && avail[ch])
        check("R4 e1 slot", {28'd0, e1_wr_slot}, {28'd0, e1s[ch]});
      check("R5 R6 tx pcm", {15'd0, pcm_wr_en, 4'd0, pcm_wr_slot, (pcm_wr_en ? pcm_wr_data : 8'd0)},
            {15'd0, (m[2] || avail[ch]), 4'd0, pcms[ch],
             (m[2] ? e1v(e1s[ch]) : (avail[ch] ? txd[ch] : 8'd0))});
      check("R7 no rx in tx", {31'd0, fifo_rx_valid}, 32'd0);
      if (need && !avail[ch]) exp_err[ch] = 1'b1;
    end else begin
      check("R7 rx fifo", {23'd0, fifo_rx_valid, fifo_rx_data},
            {23'd0, 1'b1, (m[0] ? pcmv(pcms[ch]) : e1v(e1s[ch]))});
      check("R8 rx e1", {15'd0, e1_wr_en, 4'd0, e1_wr_slot, (e1_wr_en ? e1_wr_data : 8'd0)},
            {15'd0, m[1], 4'd0, (m[1] ? e1s[ch] : e1_wr_slot), (m[1] ? pcmv(pcms[ch]) : 8'd0)});
      check("R8 R9 rx no pcm/pop", {30'd0, pcm_wr_en, fifo_tx_ready}, 32'd0);
      if (!room[ch]) exp_err[ch] = 1'b1;
    end
  endtask

  task automatic pulse_start();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    exp_err = '0;
  endtask

  // runs a whole frame; restart_at >= 0 re-pulses frame_start after that step
  task automatic run_frame(input bit listm, input int restart_at);
    int n;
    seq_mode = listm;
    n = listm ? int'(seq_len) : 2 * (int'(last_chan) + 1);
    @(negedge clk);
    pulse_start();
    for (int k = 0; k < n; k++) begin
      int ch;
      bit d;
      ch = listm ? int'(lch[k]) : k / 2;
      d  = listm ? ldir[k] : k[0];
      check_step(ch, d, listm ? "R3" : "R2");
      if (k == restart_at) begin
        pulse_start();
        check("R12 restart", {31'd0, step_valid} | 32'(seq_idx) << 4, 32'd1);
        restart_at = -1;
        k = 0;
        ch = listm ? int'(lch[0]) : 0;
        d  = listm ? ldir[0] : 1'b0;
        check_step(ch, d, "R12");
      end
      @(negedge clk);
    end
    check(listm ? "R3 end" : "R2 end", {31'd0, step_valid}, 32'd0);
    check("R10 flags", 32'(err_flags), 32'(exp_err));
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    for (int i = 0; i < NCH; i++) begin
      mode_a[i] = 3'(i); e1s[i] = SW'(2*i); pcms[i] = SW'(15-i);
      avail[i] = 1'b1; room[i] = 1'b1; txd[i] = 8'h30 + 8'(i);
    end
    for (int i = 0; i < 2*NCH; i++) begin lch[i] = '0; ldir[i] = 1'b0; end
    for (int i = 0; i < (1<<SW); i++) e1tx[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {26'd0, step_valid, fifo_tx_ready, fifo_rx_valid, e1_wr_en, pcm_wr_en, 1'b0} | 32'(err_flags) << 8, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle", {28'd0, step_valid, fifo_tx_ready, e1_wr_en, pcm_wr_en} | 32'(err_flags) << 8, 32'd0);

    // all eight modes, everything ready
    run_frame(1'b0, -1);
    // starved TX FIFOs, full RX FIFOs, permuted modes
    for (int i = 0; i < NCH; i++) begin
      mode_a[i] = 3'(7 - i); avail[i] = i[0]; room[i] = !i[1]; txd[i] = 8'hC0 + 8'(i);
    end
    run_frame(1'b0, -1);
    // modes rotated by bit 0 to separate bit 0 in TX
    for (int i = 0; i < NCH; i++) begin mode_a[i] = 3'(i) ^ 3'd1; avail[i] = !i[0]; room[i] = i[0]; end
    run_frame(1'b0, -1);
    // short walk
    last_chan = 3'd2;
    for (int i = 0; i < NCH; i++) begin avail[i] = 1'b1; room[i] = 1'b1; end
    run_frame(1'b0, -1);
    // R10 flags cleared by a clean frame
    check("R10 cleared", 32'(err_flags), 32'd0);

    // R11 shared E1 slot: channel 5 later than channel 2 in ascending order
    last_chan = 3'd7;
    for (int i = 0; i < NCH; i++) mode_a[i] = 3'd6;
    mode_a[2] = 3'd0; mode_a[5] = 3'd0; e1s[5] = e1s[2];
    txd[2] = 8'h22; txd[5] = 8'h55;
    run_frame(1'b0, -1);
    check("R11 last write", 32'(e1tx[e1s[2]]), 32'h55);

    // list mode: reversed walk, channel 2 now later
    for (int k = 0; k < 2*NCH; k++) begin lch[k] = CW'(NCH - 1 - k/2); ldir[k] = ~k[0]; end
    seq_len = 5'd16;
    run_frame(1'b1, -1);
    check("R11 R3 last write list", 32'(e1tx[e1s[2]]), 32'h22);
    // partial list with mixed modes
    for (int i = 0; i < NCH; i++) mode_a[i] = 3'(i + 3);
    seq_len = 5'd5;
    run_frame(1'b1, -1);
    // empty list
    seq_len = 5'd0;
    seq_mode = 1'b1;
    @(negedge clk);
    pulse_start();
    check("R3 empty list", {31'd0, step_valid}, 32'd0);
    @(negedge clk);
    check("R3 empty list idle", {29'd0, step_valid, e1_wr_en, pcm_wr_en}, 32'd0);

    // R12 restart mid-walk
    seq_mode = 1'b0;
    run_frame(1'b0, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule